// File: doc/BRIEF.md
# Double-Banked Operand Buffer

This block holds operand matrices for a matrix compute unit in two equal banks. At any moment one bank takes words arriving from the off-chip load path and the other bank is read by the compute unit. A load that is issued after a compute operation can therefore fill one bank while the computation still reads the other. When the incoming matrix is complete and the compute side has let go of its bank, the two banks trade roles.

The pipeline sends a compute request when it wants to start on the next operands. The block raises a stall while the compute-side bank holds nothing new since the last role exchange. It drops the stall once a completed load has been moved to the compute side. Load words that arrive while a finished load is still waiting for the exchange are dropped, so the waiting operands cannot be overwritten.

Top module: `pp_operand_buffer`

## Requirements
- R1: After reset, bank 0 takes loads and bank 1 is on the compute side. No bank is marked filled, the compute side counts as released, and a compute request is stalled.
- R2: A load word with ld_valid high is written to the load-side bank at ld_addr. rd_data shows the compute-side word at rd_addr one clock after rd_addr is sampled.
- R3: A load word with ld_last high marks the load complete. The banks exchange roles at the clock edge where the load is complete and the compute side is released. Reset releases the compute side, and so does a cmp_done pulse. Without a complete load, no exchange takes place.
- R4: When a load is complete but the compute side is not released, the roles stay as they are. Load words that arrive in that window are ignored, so the load-side bank keeps its data.
- R5: stall is high exactly when cmp_req is high and the compute side is released, meaning no operands have arrived since the last exchange. It is low in the cycle that follows an exchange.
- R6: Loads that arrive after an exchange and before cmp_done go to the other bank. They do not change the data seen on rd_data.
- R7: If the last load word and cmp_done arrive in the same cycle, the exchange happens at that clock edge.
- R8: The roles alternate on every exchange. After two exchanges, bank 0 is back on the load side and its old contents are intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | 1 | Load word present |
| ld_addr | input | 8 | Word address within the load-side bank |
| ld_data | input | 32 | Load word |
| ld_last | input | 1 | Final word of the current matrix load |
| cmp_req | input | 1 | Compute unit wants to start on the next operands |
| cmp_done | input | 1 | One-cycle pulse: computation on the compute-side bank finished |
| stall | output | 1 | Hold the pipeline; the compute-side operands are not ready |
| rd_addr | input | 8 | Compute read address |
| rd_data | output | 32 | Compute read data, one cycle of latency |

## Verification
A wrong bank select shows up on rd_data one clock after the read address is sampled: a value from the wrong bank, or one left over from an earlier matrix, comes back. A wrong completion or release flag shows up in the same cycle through stall. It also shows up later as an exchange that happens too early or never happens, which exposes stale or overwritten operands on the next read. The bench therefore places reads right after each exchange, right after each dropped write, and across the same-cycle done-and-last case.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) shift_q <= '0;
    else              shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // storage array: no reset, write enable gates the update
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl
  import pp_buf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_valid,
  input  logic  ld_last,
  input  logic  cmp_req,
  input  logic  cmp_done,
  output bank_e load_sel,
  output logic  load_full,
  output logic  cmp_free,
  output logic  wr_en,
  output logic  stall
);
  bank_e sel_d;
  logic  full_d, free_d, fill_now, free_now, swap, upd;

  always_comb begin
    wr_en    = ld_valid & ~load_full;
    fill_now = load_full | (wr_en & ld_last);
    free_now = cmp_free | cmp_done;
    swap     = fill_now & free_now;
    upd      = swap | (wr_en & ld_last) | cmp_done;
    if (swap) begin
      sel_d  = other_bank(load_sel);
      full_d = 1'b0;
      free_d = 1'b0;
    end else begin
      sel_d  = load_sel;
      full_d = fill_now;
      free_d = free_now;
    end
    stall = cmp_req & cmp_free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_sel  <= BANK_A;
      load_full <= 1'b0;
      cmp_free  <= 1'b1;
    end else if (upd) begin
      load_sel  <= sel_d;
      load_full <= full_d;
      cmp_free  <= free_d;
    end
  end
endmodule

// File: rtl/pp_operand_buffer.sv
module pp_operand_buffer
  import pp_buf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int NBANK  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_last,
  input  logic              cmp_req,
  input  logic              cmp_done,
  output logic              stall,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic              rst_sync_n;
  bank_e             load_sel;
  logic              load_full, cmp_free, wr_en;
  logic              rd_sel_q;
  logic [DATA_W-1:0] bank_q [NBANK];

  pp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_sync_n)
  );

  pp_swap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .ld_valid(ld_valid), .ld_last(ld_last),
    .cmp_req(cmp_req), .cmp_done(cmp_done), .load_sel(load_sel),
    .load_full(load_full), .cmp_free(cmp_free), .wr_en(wr_en), .stall(stall)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk(clk),
      .we(wr_en && (load_sel == bank_e'(b))),
      .waddr(ld_addr),
      .wdata(ld_data),
      .raddr(rd_addr),
      .rdata(bank_q[b])
    );
  end

  // remembers which bank was on the compute side when rd_addr was sampled
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_sel_q <= 1'b1;
    else             rd_sel_q <= ~load_sel;
  end

  assign rd_data = bank_q[rd_sel_q];
endmodule

// File: rtl/pp_operand_buffer_chk.sv
module pp_operand_buffer_chk (
  input logic clk,
  input logic rst_n,
  input logic load_sel,
  input logic load_full,
  input logic cmp_free,
  input logic cmp_done,
  input logic cmp_req,
  input logic stall,
  input logic ld_valid,
  input logic ld_last
);
  // R3: roles change only after a complete load meets a released compute side
  assert_swap_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel != $past(load_sel)) |->
      $past((load_full || (ld_valid && ld_last)) && (cmp_free || cmp_done)));

  // R5: compute side is never starved right after an exchange
  assert_no_stall_after_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel != $past(load_sel)) |-> !stall);

  // R4: a complete load waits, unchanged, for the compute side
  assert_hold_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_full && !cmp_free && !cmp_done) |=> (load_full && $stable(load_sel)));

  // R3: a release with no pending load persists and stalls a request
  assert_release_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && !load_full && !(ld_valid && ld_last)) |=> (cmp_free && (cmp_req == stall)));
endmodule

bind pp_operand_buffer pp_operand_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .load_sel(load_sel), .load_full(load_full),
  .cmp_free(cmp_free), .cmp_done(cmp_done), .cmp_req(cmp_req), .stall(stall),
  .ld_valid(ld_valid), .ld_last(ld_last)
);

// File: tb/tb_pp_operand_buffer.sv
`timescale 1ns/1ps
module tb_pp_operand_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_last = 1'b0, cmp_req = 1'b0, cmp_done = 1'b0;
  logic [7:0]  ld_addr = '0, rd_addr = '0;
  logic [31:0] ld_data = '0;
  logic        stall;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  logic rd_go = 1'b0, rd_go_d = 1'b0;
  logic [31:0] exp_q [$];
  string tag_q [$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pp_operand_buffer dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .ld_last(ld_last), .cmp_req(cmp_req), .cmp_done(cmp_done),
    .stall(stall), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one cycle after a read is launched, pop and compare
  always @(posedge clk) rd_go_d <= rd_go;
  always @(negedge clk) begin
    if (rd_go_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rd_data, e, t);
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_addr = a; rd_go = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_go = 1'b0;
  endtask

  task automatic ld(input logic [7:0] a, input logic [31:0] d, input logic last,
                    input logic done);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d; ld_last = last; cmp_done = done;
    @(negedge clk);
    ld_valid = 1'b0; ld_last = 1'b0; cmp_done = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); cmp_done = 1'b1;
    @(negedge clk); cmp_done = 1'b0;
  endtask

  task automatic stall_chk(input logic e, input string t);
    @(negedge clk); cmp_req = 1'b1;
    #1 check({31'd0, stall}, {31'd0, e}, t);
    @(negedge clk); cmp_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({31'd0, stall}, 32'd0, "R1 stall low without request");
    stall_chk(1'b1, "R1 R5 request stalled after reset");

    // R2 R3: fill bank 0; compute side is released from reset, so it swaps at once
    for (int i = 0; i < 4; i++) ld(8'(i), 32'hA000_0000 + i, i == 3, 1'b0);
    for (int i = 0; i < 4; i++) rd(8'(i), 32'hA000_0000 + i, "R2 R3 bank0 operands visible");
    stall_chk(1'b0, "R5 no stall after exchange");

    // R6: load bank 1 during computation
    for (int i = 0; i < 4; i++) ld(8'(i), 32'hB000_0000 + i, i == 3, 1'b0);
    rd(8'd0, 32'hA000_0000, "R6 read undisturbed by loads");
    // R4: no release yet, write ignored
    ld(8'd0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    rd(8'd1, 32'hA000_0001, "R4 no exchange before done");
    stall_chk(1'b0, "R4 R5 operands still held");
    done_pulse();
    rd(8'd0, 32'hB000_0000, "R4 ignored write kept bank1 data");
    rd(8'd3, 32'hB000_0003, "R8 second exchange to bank1");

    // R7: last word and done together
    ld(8'd5, 32'hC000_0005, 1'b1, 1'b1);
    rd(8'd5, 32'hC000_0005, "R7 same-cycle done and last swap");
    rd(8'd0, 32'hA000_0000, "R8 bank0 returns with old contents");

    // R3: release without pending load does not swap
    done_pulse();
    stall_chk(1'b1, "R5 stall after release without load");
    rd(8'd5, 32'hC000_0005, "R3 no exchange without complete load");

    ld(8'd7, 32'hD000_0007, 1'b1, 1'b0);
    rd(8'd7, 32'hD000_0007, "R3 released side swaps on load last");
    rd(8'd0, 32'hB000_0000, "R8 bank1 back on compute side");
    stall_chk(1'b0, "R5 stall clears after exchange");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule